// File: doc/BRIEF.md
# Hexadecimal Seven-Segment Decoder

This combinational block turns a 4-bit value into drive levels for a seven-segment digit. It can show all sixteen codes: the digits 0 to 9 and the letters A, b, C, d, E and F. The lowercase b and d keep those two letters from looking like 8 and 0. The segment outputs are active low, so a 0 lights a segment. A group of output drivers, switched together, can release all seven segment pins to high impedance, which lets several decoders share one set of segment lines.

Three control inputs sit on top of the decode. A lamp-test input turns every segment on. A zero-blanking input turns every segment off when the code is zero. A ripple output reports that this digit was blanked. To suppress leading zeros on a multi-digit display, the ripple output of the more significant digit feeds the blanking input of the next digit. Each segment is built as a sum of product terms, with a hard limit of seven terms per segment. The lamp-test override uses one of those seven terms.

Top module: `hexseg_decoder`

## Requirements
- R1: `seg_n_o` bit 0 drives segment a, bit 1 b, bit 2 c, bit 3 d, bit 4 e, bit 5 f and bit 6 g. A driven 0 lights the segment. For example, code 1 with no override gives 7'b1111001.
- R2: With no override active, codes 0 to 9 light these segments. 0: abcdef. 1: bc. 2: abdeg. 3: abcdg. 4: bcfg. 5: acdfg. 6: acdefg. 7: abc. 8: all seven. 9: abcdfg.
- R3: With no override active, codes 10 to 15 light these segments. 10 (A): abcefg. 11 (b): cdefg. 12 (C): adef. 13 (d): bcdeg. 14 (E): adefg. 15 (F): aefg.
- R4: While `lt_n_i` is 0, all seven segments are lit for every code and every blanking level. Lamp test wins over blanking.
- R5: While `lt_n_i` is 1, `rbi_n_i` is 0 and the code is 0, all seven segments are off and `rbo_n_o` is 0.
- R6: In every other input combination `rbo_n_o` is 1. When `rbi_n_i` is 0 and the code is not zero, the normal glyph is shown.
- R7: While `oe_n_i` is 1, all seven segment outputs are high impedance. `rbo_n_o` stays driven regardless of `oe_n_i`.
- R8: No clock is involved. A change on any input reaches the outputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | 4 | Value to display, bit 0 least significant |
| lt_n_i | input | 1 | Lamp test, active low |
| rbi_n_i | input | 1 | Zero-blanking request from the more significant digit, active low |
| oe_n_i | input | 1 | Segment output enable, active low |
| seg_n_o | output | 7 | Segment drives a..g, active low, high impedance when disabled |
| rbo_n_o | output | 1 | Ripple output, low when this digit was blanked |

## Verification
The block holds no state. A wrong product term shows up at once as a single segment in the wrong state for one or a few specific codes. A wrong override priority shows up as the wrong glyph, or as a wrong ripple level, for one particular combination of lamp test, blanking and code. The bench therefore checks all 128 combinations of code, lamp test, blanking and enable. It checks both outputs in the same time step as the stimulus, with no clock edge in between, so that any dependence on a register or on stale state is also exposed.

// File: rtl/hexseg_pkg.sv
package hexseg_pkg;

    localparam int CODE_W      = 4;
    localparam int SEG_W       = 7;
    localparam int TERM_BUDGET = 7;
    localparam int DATA_TERMS  = TERM_BUDGET - 1;   // one term kept for lamp test

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_W-1:0]  seg_t;

    typedef enum int {
        SEG_A = 0, SEG_B = 1, SEG_C = 2, SEG_D = 3,
        SEG_E = 4, SEG_F = 5, SEG_G = 6
    } seg_idx_e;

    // One product term: bits set in care take part, want gives their polarity.
    typedef struct packed {
        logic  used;
        code_t care;
        code_t want;
    } cube_t;

    typedef struct packed {
        logic lamp;       // lamp test requested
        logic blank_req;  // zero blanking requested
        logic drive;      // outputs enabled
    } ctrl_t;

    localparam cube_t NO_CUBE = '{used: 1'b0, care: '0, want: '0};

    function automatic cube_t mk(input code_t care, input code_t want);
        return '{used: 1'b1, care: care, want: want};
    endfunction

    function automatic logic cube_hit(input cube_t c, input code_t x);
        return c.used && ((x & c.care) == (c.want & c.care));
    endfunction

    // Minimised cover for each segment, literals ordered D3 D2 D1 D0.
    function automatic cube_t seg_cube(input int s, input int k);
        cube_t r;
        r = NO_CUBE;
        case (s)
            SEG_A: case (k)
                0: r = mk(4'b0101, 4'b0000);
                1: r = mk(4'b1001, 4'b1000);
                2: r = mk(4'b1010, 4'b0010);
                3: r = mk(4'b0110, 4'b0110);
                4: r = mk(4'b1101, 4'b0101);
                5: r = mk(4'b1110, 4'b1000);
                default: r = NO_CUBE;
            endcase
            SEG_B: case (k)
                0: r = mk(4'b1100, 4'b0000);
                1: r = mk(4'b0110, 4'b0000);
                2: r = mk(4'b1011, 4'b0000);
                3: r = mk(4'b1011, 4'b0011);
                4: r = mk(4'b1011, 4'b1001);
                5: r = mk(4'b1101, 4'b1000);
                default: r = NO_CUBE;
            endcase
            SEG_C: case (k)
                0: r = mk(4'b1001, 4'b0001);
                1: r = mk(4'b1100, 4'b0100);
                2: r = mk(4'b0110, 4'b0000);
                3: r = mk(4'b1100, 4'b1000);
                4: r = mk(4'b0011, 4'b0001);
                default: r = NO_CUBE;
            endcase
            SEG_D: case (k)
                0: r = mk(4'b1010, 4'b1000);
                1: r = mk(4'b1101, 4'b0000);
                2: r = mk(4'b0111, 4'b0011);
                3: r = mk(4'b0111, 4'b0110);
                4: r = mk(4'b0111, 4'b0101);
                default: r = NO_CUBE;
            endcase
            SEG_E: case (k)
                0: r = mk(4'b0101, 4'b0000);
                1: r = mk(4'b0011, 4'b0010);
                2: r = mk(4'b1100, 4'b1100);
                3: r = mk(4'b1010, 4'b1010);
                default: r = NO_CUBE;
            endcase
            SEG_F: case (k)
                0: r = mk(4'b0011, 4'b0000);
                1: r = mk(4'b1110, 4'b0100);
                2: r = mk(4'b0101, 4'b0100);
                3: r = mk(4'b1100, 4'b1000);
                4: r = mk(4'b1010, 4'b1010);
                default: r = NO_CUBE;
            endcase
            SEG_G: case (k)
                0: r = mk(4'b0110, 4'b0010);
                1: r = mk(4'b0011, 4'b0010);
                2: r = mk(4'b1110, 4'b0100);
                3: r = mk(4'b1100, 4'b1000);
                4: r = mk(4'b1001, 4'b1001);
                5: r = mk(4'b1010, 4'b1010);
                default: r = NO_CUBE;
            endcase
            default: r = NO_CUBE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hexseg_term_plane.sv
module hexseg_term_plane
    import hexseg_pkg::*;
#(
    parameter int SEG_IDX = 0
) (
    input  code_t code_i,
    output logic  lit_o
);
    logic [DATA_TERMS-1:0] hit;

    for (genvar k = 0; k < DATA_TERMS; k++) begin : g_term
        localparam cube_t CUBE = seg_cube(SEG_IDX, k);
        assign hit[k] = cube_hit(CUBE, code_i);
    end

    assign lit_o = |hit;
endmodule

// File: rtl/hexseg_sop.sv
module hexseg_sop
    import hexseg_pkg::*;
(
    input  code_t code_i,
    output seg_t  lit_o
);
    for (genvar s = 0; s < SEG_W; s++) begin : g_seg
        hexseg_term_plane #(.SEG_IDX(s)) plane_i (
            .code_i (code_i),
            .lit_o  (lit_o[s])
        );
    end

    // Every glyph, letters included, lights at least two segments.
    always_comb begin
        p_glyph_min_r2: assert ($countones(lit_o) >= 2)
            else $error("glyph with fewer than two segments (R2/R3)");
    end
endmodule

// File: rtl/hexseg_blank.sv
module hexseg_blank
    import hexseg_pkg::*;
(
    input  ctrl_t ctrl_i,
    input  code_t code_i,
    input  seg_t  raw_lit_i,
    output seg_t  lit_o,
    output logic  rbo_n_o
);
    logic zero_blank;

    always_comb begin
        zero_blank = ctrl_i.blank_req && !ctrl_i.lamp && (code_i == '0);
        if (ctrl_i.lamp)
            lit_o = '1;
        else if (zero_blank)
            lit_o = '0;
        else
            lit_o = raw_lit_i;
        rbo_n_o = !zero_blank;
    end

    always_comb begin
        if (ctrl_i.lamp) begin
            p_lamp_all_r4: assert (lit_o == '1 && rbo_n_o)
                else $error("lamp test not dominant (R4)");
        end
        if (!rbo_n_o) begin
            p_ripple_dark_r5: assert (lit_o == '0 && code_i == '0)
                else $error("ripple asserted with a lit or nonzero digit (R5)");
        end
        if (!ctrl_i.blank_req) begin
            p_ripple_idle_r6: assert (rbo_n_o && lit_o == raw_lit_i || ctrl_i.lamp)
                else $error("blanking effect without request (R6)");
        end
    end
endmodule

// File: rtl/hexseg_drive.sv
module hexseg_drive #(
    parameter int W = 7
) (
    input  logic         en_i,
    input  logic [W-1:0] lit_i,
    output logic [W-1:0] pin_n_o
);
    assign pin_n_o = en_i ? ~lit_i : {W{1'bz}};
endmodule

// File: rtl/hexseg_decoder.sv
module hexseg_decoder
    import hexseg_pkg::*;
(
    input  logic [3:0] code_i,
    input  logic       lt_n_i,
    input  logic       rbi_n_i,
    input  logic       oe_n_i,
    output logic [6:0] seg_n_o,
    output logic       rbo_n_o
);
    ctrl_t ctrl;
    seg_t  raw_lit;
    seg_t  lit;

    assign ctrl = '{lamp: !lt_n_i, blank_req: !rbi_n_i, drive: !oe_n_i};

    hexseg_sop sop_i (
        .code_i (code_i),
        .lit_o  (raw_lit)
    );

    hexseg_blank blank_i (
        .ctrl_i    (ctrl),
        .code_i    (code_i),
        .raw_lit_i (raw_lit),
        .lit_o     (lit),
        .rbo_n_o   (rbo_n_o)
    );

    hexseg_drive #(.W(SEG_W)) drive_i (
        .en_i    (ctrl.drive),
        .lit_i   (lit),
        .pin_n_o (seg_n_o)
    );
endmodule

// File: tb/hexseg_decoder_tb_top.sv
module hexseg_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] code;
    logic       lt_n, rbi_n, oe_n;
    wire  [6:0] seg_n;
    wire        rbo_n;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         finished = 1'b0;

    // Released pins read low through the bench pulldowns.
    for (genvar i = 0; i < 7; i++) begin : g_pd
        pulldown pd_i (seg_n[i]);
    end

    always #4 clk = ~clk;   // 125 MHz

    // Lit pattern per code, bit 0 = a ... bit 6 = g.
    localparam logic [6:0] GLYPH [16] = '{
        7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
        7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71
    };

    hexseg_decoder dut_i (
        .code_i  (code),
        .lt_n_i  (lt_n),
        .rbi_n_i (rbi_n),
        .oe_n_i  (oe_n),
        .seg_n_o (seg_n),
        .rbo_n_o (rbo_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: code=%0d lt_n=%0b rbi_n=%0b oe_n=%0b actual=%b expected=%b",
                     req, code, lt_n, rbi_n, oe_n, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        code = 4'd0; lt_n = 1'b1; rbi_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 reset state seg", {1'b0, seg_n}, 8'h00);
        check("R6 reset state rbo", {7'b0, rbo_n}, 8'h01);
        rst = 1'b0;

        // Exhaustive walk of code, lamp test, blanking and enable.
        for (int v = 0; v < 128; v++) begin
            logic [6:0] exp_lit;
            logic [6:0] exp_seg;
            logic       exp_rbo;
            logic       blank;
            string      tag;
            @(posedge clk);
            #1;
            code  = v[3:0];
            lt_n  = v[4];
            rbi_n = v[5];
            oe_n  = v[6];
            @(negedge clk);
            blank = lt_n && !rbi_n && (code == 4'd0);
            if (!lt_n)      begin exp_lit = 7'h7F; tag = "R4"; end
            else if (blank) begin exp_lit = 7'h00; tag = "R5"; end
            else begin
                exp_lit = GLYPH[code];
                tag = (code < 4'd10) ? "R2" : "R3";
            end
            if (oe_n) begin exp_seg = 7'h00; tag = "R7"; end
            else exp_seg = ~exp_lit;
            exp_rbo = !blank;
            check({tag, " seg"}, {1'b0, seg_n}, {1'b0, exp_seg});
            check(blank ? "R5 rbo" : "R6 rbo", {7'b0, rbo_n}, {7'b0, exp_rbo});
        end

        // R1: bit order and polarity for digit 1.
        @(posedge clk); #1;
        code = 4'd1; lt_n = 1'b1; rbi_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        check("R1 bit order", {1'b0, seg_n}, 8'b01111001);

        // R8: no clock edge between stimulus and sample.
        @(negedge clk); #1;
        code = 4'd8;
        #1;
        check("R8 no clock", {1'b0, seg_n}, 8'h00);
        code = 4'd13;
        #1;
        check("R8 no clock d", {1'b0, seg_n}, {1'b0, ~7'h5E});

        // R5 then R6: blanked zero, then the same zero unblanked.
        @(posedge clk); #1;
        code = 4'd0; rbi_n = 1'b0;
        @(negedge clk);
        check("R5 blank zero", {rbo_n, seg_n}, 8'h7F);
        @(posedge clk); #1;
        rbi_n = 1'b1;
        @(negedge clk);
        check("R6 zero shown", {rbo_n, seg_n}, {1'b1, ~7'h3F});

        // R6: blanking request with a nonzero code keeps the glyph.
        @(posedge clk); #1;
        code = 4'd11; rbi_n = 1'b0;
        @(negedge clk);
        check("R6 nonzero kept", {rbo_n, seg_n}, {1'b1, ~7'h7C});

        // R4: lamp test over blanking at code zero.
        @(posedge clk); #1;
        code = 4'd0; lt_n = 1'b0; rbi_n = 1'b0;
        @(negedge clk);
        check("R4 lamp over blank", {rbo_n, seg_n}, 8'h80);

        // R7: ripple still driven while segments are released.
        @(posedge clk); #1;
        lt_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        check("R7 rbo while off", {rbo_n, seg_n}, 8'h00);

        finish_run();
    end
endmodule